// File: doc/BRIEF.md
# Cache Line SEC-DED Check-Byte Verifier

This block verifies the stored check bytes of one data-cache line. A line is four 64-bit doublewords, and each doubleword carries its own 8-bit check byte. The doublewords arrive as a stream of beats qualified by a valid strobe, one beat per accepted cycle. Each beat carries the doubleword, its stored check byte and its offset within the line. For every beat the block recomputes eight check bits from the data. It XORs them with the stored byte to form a syndrome, and it sorts any mismatch into a single-bit class or a multi-bit class.

The results build up over the line. A bad mask holds one bit per offset, and two sticky flags record the single-bit and multi-bit classes seen so far in the line. A one-cycle completion pulse marks the point where the whole line has been checked. The block only reports errors. It does not correct data and it does not write anything back.

Top module: `line_ecc_checker`

## Requirements
- R1: Computed check bit i (i = 0..7) is the XOR of all bits of (data AND mask i). Mask 0 is 0x0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits, so mask 7 is 0xFF0738C808099264. A beat whose stored byte equals the computed code raises no error.
- R2: The syndrome is the computed code XOR the stored byte. A nonzero syndrome on an accepted beat at offset k sets bad_mask bit (3 - k), so offset 0 maps to bit 3 and offset 3 maps to bit 0.
- R3: A syndrome with exactly one bit set raises err_single.
- R4: A nonzero syndrome with two or more bits set raises err_multi. A single beat never raises both classes.
- R5: Within a line, bad_mask bits, err_single and err_multi accumulate as the OR over all accepted beats.
- R6: An accepted beat at offset 0 starts a new line. The earlier mask and flags are discarded, and the outputs then reflect only that beat.
- R7: line_done is high for exactly the one cycle that follows the acceptance of an offset-3 beat.
- R8: The results are registered and update on the clock edge that accepts a beat. With beat_valid low, bad_mask, err_single and err_multi hold their values.
- R9: After reset, bad_mask, err_single, err_multi and line_done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_valid | input | 1 | The beat on the inputs is accepted this cycle |
| beat_offset | input | 2 | Offset of the doubleword within the line (0..3) |
| beat_data | input | 64 | Doubleword as read from the line |
| beat_check | input | 8 | Check byte stored with the doubleword |
| bad_mask | output | 4 | Per-offset mismatch mask, bit (3 - offset) |
| err_single | output | 1 | A single-bit syndrome was seen in the current line |
| err_multi | output | 1 | A multi-bit syndrome was seen in the current line |
| line_done | output | 1 | One-cycle pulse after the offset-3 beat is accepted |

## Verification
Five properties are checked on every cycle. The two syndrome classes never occur together. A bad beat always lands in the mask. An offset-0 beat leaves only the top mask bit possible. Idle cycles leave the results untouched. A line_done pulse is always preceded by an accepted offset-3 beat. Only the bench scenarios can show the parts that depend on values. These are the mask constants and their rotation, the exact single/multi split for flips in data versus flips in the check byte, the mapping from offset to mask bit, and the OR-accumulation across a full line, including a line restarted before it completes.

// File: rtl/ecc_line_pkg.sv
package ecc_line_pkg;

   // default base pattern for check bit 0; further bits rotate it
   localparam logic [63:0] ECC_MASK_BASE = 64'h0738_C808_0992_64FF;

   // how the classifier recognises a one-hot syndrome
   typedef enum logic [0:0] {
      CLASS_POPCOUNT = 1'b0,
      CLASS_CLEARLOW = 1'b1
   } class_style_e;

   // verdict of one beat
   typedef struct packed {
      logic bad;
      logic single;
      logic multi;
   } beat_class_t;

endpackage

// File: rtl/ecc_checkbit_gen.sv
module ecc_checkbit_gen #(
   parameter int unsigned        DATA_W = 64,
   parameter int unsigned        CHK_W  = 8,
   parameter logic [DATA_W-1:0]  MASK0  = ecc_line_pkg::ECC_MASK_BASE
) (
   input  logic [DATA_W-1:0] data_in,
   output logic [CHK_W-1:0]  code_out
);
   localparam int unsigned ROT = DATA_W / CHK_W;

   if (CHK_W < 2 || DATA_W % CHK_W != 0) begin : g_bad_geometry
      $error("ecc_checkbit_gen: DATA_W must be a multiple of CHK_W >= 2");
   end

   for (genvar i = 0; i < CHK_W; i++) begin : g_bit
      // mask i: base pattern rotated left by ROT*i bits
      localparam logic [DATA_W-1:0] MASK_I = (i == 0) ? MASK0 :
         ((MASK0 << (ROT * i)) | (MASK0 >> (DATA_W - ROT * i)));
      assign code_out[i] = ^(data_in & MASK_I);
   end
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify #(
   parameter int unsigned               CHK_W = 8,
   parameter ecc_line_pkg::class_style_e STYLE = ecc_line_pkg::CLASS_POPCOUNT
) (
   input  logic [CHK_W-1:0]         computed,
   input  logic [CHK_W-1:0]         stored,
   output logic [CHK_W-1:0]         syndrome,
   output ecc_line_pkg::beat_class_t verdict
);
   localparam int unsigned CNT_W = $clog2(CHK_W + 1);

   logic nonzero;
   logic one_hot;

   assign syndrome = computed ^ stored;
   assign nonzero  = |syndrome;

   if (STYLE == ecc_line_pkg::CLASS_POPCOUNT) begin : g_popcount
      logic [CNT_W-1:0] ones;
      always_comb begin
         ones = '0;
         for (int b = 0; b < CHK_W; b++) begin
            ones = ones + CNT_W'(syndrome[b]);
         end
      end
      assign one_hot = (ones == CNT_W'(1));
   end else begin : g_clearlow
      // clearing the lowest set bit leaves zero only for one-hot values
      assign one_hot = nonzero && ((syndrome & (syndrome - CHK_W'(1))) == '0);
   end

   always_comb begin
      verdict.bad    = nonzero;
      verdict.single = one_hot;
      verdict.multi  = nonzero && !one_hot;
   end
endmodule

// File: rtl/ecc_line_accum.sv
module ecc_line_accum #(
   parameter int unsigned BEATS = 4,
   localparam int unsigned OFF_W = $clog2(BEATS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      beat_valid,
   input  logic [OFF_W-1:0]          beat_offset,
   input  ecc_line_pkg::beat_class_t verdict,
   output logic [BEATS-1:0]          bad_mask,
   output logic                      err_single,
   output logic                      err_multi,
   output logic                      line_done
);
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BEATS - 1);

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("ecc_line_accum: BEATS must be a power of two >= 2");
   end

   logic [BEATS-1:0] hit;
   logic             first_beat;

   // offset k selects mask bit BEATS-1-k
   for (genvar b = 0; b < BEATS; b++) begin : g_hit
      assign hit[b] = (beat_offset == OFF_W'(BEATS - 1 - b));
   end

   assign first_beat = (beat_offset == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_mask   <= '0;
         err_single <= 1'b0;
         err_multi  <= 1'b0;
         line_done  <= 1'b0;
      end else begin
         line_done <= beat_valid && (beat_offset == LAST_OFF);
         if (beat_valid) begin
            if (first_beat) begin
               bad_mask   <= hit & {BEATS{verdict.bad}};
               err_single <= verdict.single;
               err_multi  <= verdict.multi;
            end else begin
               bad_mask   <= bad_mask | (hit & {BEATS{verdict.bad}});
               err_single <= err_single | verdict.single;
               err_multi  <= err_multi | verdict.multi;
            end
         end
      end
   end

   assert_bad_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && verdict.bad) |=> ((bad_mask & $past(hit)) != '0))
      else $error("bad beat missing from mask");

   assert_new_line_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && first_beat) |=> (bad_mask[BEATS-2:0] == '0))
      else $error("stale mask bits after line start");

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |=> ($stable(bad_mask) && $stable(err_single) && $stable(err_multi)))
      else $error("results moved without a beat");

   assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> $past(beat_valid && beat_offset == LAST_OFF))
      else $error("line_done without final beat");

   assert_flags_need_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_single || err_multi) |-> (bad_mask != '0))
      else $error("flag raised with empty mask");
endmodule

// File: rtl/line_ecc_checker.sv
module line_ecc_checker #(
   parameter int unsigned                DATA_W = 64,
   parameter int unsigned                CHK_W  = 8,
   parameter int unsigned                BEATS  = 4,
   parameter logic [DATA_W-1:0]          MASK0  = ecc_line_pkg::ECC_MASK_BASE,
   parameter ecc_line_pkg::class_style_e STYLE  = ecc_line_pkg::CLASS_POPCOUNT,
   localparam int unsigned               OFF_W  = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [OFF_W-1:0]  beat_offset,
   input  logic [DATA_W-1:0] beat_data,
   input  logic [CHK_W-1:0]  beat_check,
   output logic [BEATS-1:0]  bad_mask,
   output logic              err_single,
   output logic              err_multi,
   output logic              line_done
);
   logic [CHK_W-1:0]          code;
   logic [CHK_W-1:0]          syndrome;
   ecc_line_pkg::beat_class_t verdict;

   ecc_checkbit_gen #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .MASK0  (MASK0)
   ) u_gen (
      .data_in  (beat_data),
      .code_out (code)
   );

   ecc_syndrome_classify #(
      .CHK_W (CHK_W),
      .STYLE (STYLE)
   ) u_cls (
      .computed (code),
      .stored   (beat_check),
      .syndrome (syndrome),
      .verdict  (verdict)
   );

   ecc_line_accum #(
      .BEATS (BEATS)
   ) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .beat_valid  (beat_valid),
      .beat_offset (beat_offset),
      .verdict     (verdict),
      .bad_mask    (bad_mask),
      .err_single  (err_single),
      .err_multi   (err_multi),
      .line_done   (line_done)
   );

   assert_class_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !(verdict.single && verdict.multi))
      else $error("beat classed both single and multi");

   assert_zero_syndrome_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && syndrome == '0) |-> !(verdict.bad || verdict.single || verdict.multi))
      else $error("clean beat flagged");
endmodule

// File: tb/line_ecc_checker_test.sv
module line_ecc_checker_test;
   localparam int unsigned CLK_PERIOD = 10;
   localparam logic [63:0] BASE = 64'h0738C808099264FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        beat_valid = 1'b0;
   logic [1:0]  beat_offset = 2'd0;
   logic [63:0] beat_data = 64'd0;
   logic [7:0]  beat_check = 8'd0;
   logic [3:0]  bad_mask;
   logic        err_single;
   logic        err_multi;
   logic        line_done;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_mask = 4'd0;
   logic       exp_sbe = 1'b0;
   logic       exp_dbe = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   line_ecc_checker uut (
      .clk (clk), .rst_n (rst_n), .beat_valid (beat_valid),
      .beat_offset (beat_offset), .beat_data (beat_data), .beat_check (beat_check),
      .bad_mask (bad_mask), .err_single (err_single), .err_multi (err_multi),
      .line_done (line_done)
   );

   function automatic logic [7:0] model_code(logic [63:0] d);
      logic [7:0] c;
      for (int i = 0; i < 8; i++) begin
         logic [63:0] m;
         m = (i == 0) ? BASE : ((BASE << (8 * i)) | (BASE >> (64 - 8 * i)));
         c[i] = ^(d & m);
      end
      return c;
   endfunction

   function automatic int ones8(logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_outputs(string req, logic done_exp);
      check({req, " mask"}, 32'(bad_mask), 32'(exp_mask));
      check({req, " single"}, 32'(err_single), 32'(exp_sbe));
      check({req, " multi"}, 32'(err_multi), 32'(exp_dbe));
      check({req, " done"}, 32'(line_done), 32'(done_exp));
   endtask

   // drive one beat, update the model, then sample one step after the edge
   task automatic send(logic [1:0] off, logic [63:0] d, logic [7:0] chk, string req);
      logic [7:0] syn;
      syn = model_code(d) ^ chk;
      beat_valid  = 1'b1;
      beat_offset = off;
      beat_data   = d;
      beat_check  = chk;
      if (off == 2'd0) begin
         exp_mask = 4'd0; exp_sbe = 1'b0; exp_dbe = 1'b0;
      end
      if (syn != 8'd0) exp_mask[3 - off] = 1'b1;
      if (ones8(syn) == 1) exp_sbe = 1'b1;
      if (ones8(syn) > 1) exp_dbe = 1'b1;
      @(posedge clk);
      #1;
      beat_valid = 1'b0;
      check_outputs(req, off == 2'd3);
   endtask

   task automatic idle(string req);
      beat_data  = {$urandom, $urandom};
      beat_check = 8'($urandom);
      @(posedge clk);
      #1;
      check_outputs(req, 1'b0);
   endtask

   initial begin
      int unsigned seed;
      logic [63:0] d;
      seed = $urandom(32'd20240611);
      #(CLK_PERIOD * 3);
      #1;
      check_outputs("R9 reset", 1'b0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R1: known patterns with correct codes are clean
      d = 64'hFFFF_FFFF_FFFF_FFFF;
      check("R1 all-ones code", 32'(model_code(d)), 32'h0);
      check("R1 bit0 column", 32'(model_code(64'h1)), 32'h23);
      send(2'd0, 64'd0, 8'd0, "R1 zero");
      send(2'd1, d, model_code(d), "R1 ones");
      send(2'd2, 64'h0123_4567_89AB_CDEF, model_code(64'h0123_4567_89AB_CDEF), "R1 pattern");
      send(2'd3, 64'hA5A5_5A5A_0F0F_F0F0, model_code(64'hA5A5_5A5A_0F0F_F0F0), "R1 R7 clean line");
      idle("R7 done drops");

      // R3/R4/R2: single check-bit flip, double flip, data-bit flip
      send(2'd0, 64'h1111, model_code(64'h1111) ^ 8'h10, "R3 one check bit");
      send(2'd1, 64'h2222, model_code(64'h2222), "R2 clean keeps");
      send(2'd2, 64'h3333, model_code(64'h3333) ^ 8'h81, "R4 two check bits");
      send(2'd3, 64'h4444 ^ 64'h1, model_code(64'h4444), "R4 data bit0 three-bit syndrome");
      check("R2 offset map", 32'(bad_mask), 32'hB);
      idle("R8 hold");
      idle("R8 hold again");

      // R6: restart mid-line discards earlier results
      send(2'd0, 64'h5, model_code(64'h5) ^ 8'hFF, "R4 all syndrome bits");
      send(2'd1, 64'h6, model_code(64'h6) ^ 8'h02, "R5 accumulate");
      send(2'd0, 64'h7, model_code(64'h7), "R6 restart clean");
      check("R6 cleared", 32'(bad_mask), 32'h0);
      send(2'd3, 64'h8, model_code(64'h8) ^ 8'h04, "R2 offset3 bit0");

      // random lines with gaps
      for (int line = 0; line < 300; line++) begin
         for (int off = 0; off < 4; off++) begin
            logic [7:0] flip;
            logic [63:0] dd;
            dd = {$urandom, $urandom};
            case ($urandom % 4)
               0: flip = 8'd0;
               1: flip = 8'd1 << ($urandom % 8);
               2: begin flip = 8'd0; dd = dd ^ (64'd1 << ($urandom % 64)); end
               default: flip = 8'($urandom);
            endcase
            send(2'(off), dd, model_code({beat_data[63:0] & 64'd0} | (flip == 8'd0 && dd != 64'd0 ? dd : dd)) ^ flip, "R5 random");
            if ($urandom % 5 == 0) idle("R8 random gap");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule